// File: doc/BRIEF.md
# Serial Port FIFO Level Flags

This block holds the byte queues and the status flags of an asynchronous serial port. The host writes bytes into a transmit queue that the transmit shift engine drains. The receive shift engine delivers finished frames into a receive queue that the host reads. Both queues hold up to `DEPTH` bytes. A single 16-bit level word reports both fill counts.

Two flags follow the queue levels. Each one is compared against a trigger count that a 2-bit select picks. The transmit flag asks for more data, and the receive flag asks for data to be taken away. Three more flags record framing errors, parity errors and a detected line break. Software clears any flag in two steps: it reads the status with the flag at 1, then writes 0 to that bit. A level flag comes straight back if its condition still holds.

A frame that is all zeros and carries a framing error counts as a break. From that frame on, received bytes are not stored until the engine reports a full idle character time on the line. The shift engines themselves sit outside this block and connect through strobes.

Top module: `sport_fifo_flags`

## Requirements
- R1: After a synchronous reset both queues are empty, `level_q` is 0, `txe_valid` is 0 and `stat_q` is 5'b00001: only the transmit flag is set.
- R2: The transmit queue delivers bytes on `txe_data` in write order. A host write to a full queue is ignored and leaves the count at `DEPTH`.
- R3: The receive queue presents bytes on `host_rdata` in arrival order. A host read of an empty queue is ignored and leaves the count at 0.
- R4: `level_q` carries the transmit count in bits 14:8 and the receive count in bits 6:0. Bits 15 and 7 are 0.
- R5: Status bit 0 (transmit flag) is set on the clock edge after the transmit count is less than or equal to the trigger. `tx_trig_sel` values 0, 1, 2 and 3 select triggers of 8, 4, 2 and 1.
- R6: Status bit 1 (receive flag) is set on the clock edge after the receive count is greater than or equal to the trigger. `rx_trig_sel` values 0, 1, 2 and 3 select triggers of 1, 4, 8 and 14.
- R7: Clearing a level flag while its condition still holds leaves the flag at 1.
- R8: Writing 0 to a status bit clears it only if an earlier `stat_rd` read saw that bit as 1, with no status write in between. Writing 1 has no effect.
- R9: A push and a pop on the same queue in the same cycle leave that queue's count unchanged.
- R10: A frame strobe with `rxe_ferr` sets status bit 2. A frame strobe with `rxe_perr` sets status bit 3. Such frames are still stored.
- R11: A frame with data 0 and `rxe_ferr` sets status bit 4 and enters the break state. That frame, and every frame until the break state ends, is not stored.
- R12: An `rxe_idle` strobe ends the break state, and the next frame is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_trig_sel | input | 2 | Transmit trigger select |
| rx_trig_sel | input | 2 | Receive trigger select |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe (pops the receive queue) |
| host_rdata | output | 8 | Head of the receive queue |
| txe_take | input | 1 | Transmit engine pops a byte |
| txe_data | output | 8 | Head of the transmit queue |
| txe_valid | output | 1 | Transmit queue is not empty |
| rxe_done | input | 1 | Receive engine finished a frame |
| rxe_data | input | 8 | Received byte |
| rxe_ferr | input | 1 | Framing error on this frame |
| rxe_perr | input | 1 | Parity error on this frame |
| rxe_idle | input | 1 | Line was high for a full character time |
| stat_rd | input | 1 | Status read strobe (arms the clears) |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 5 | Status write data; a 0 bit requests a clear |
| stat_q | output | 5 | Flags: bit0 tx, bit1 rx, bit2 framing, bit3 parity, bit4 break |
| level_q | output | 16 | Queue counts word |

## Verification
The bench builds the block at its default depth of 16. At that depth, every fill level from 0 to full is reachable for all four trigger selects of each queue. At every level the bench clears the flag and compares it with the arithmetic trigger comparison, which exercises both the set rule and the re-assertion. Draining each full queue checks byte order and the ignored overflow and underflow accesses. Directed sequences then cover simultaneous push and pop, a clear without a prior read, the error flags, and entering and leaving the break state.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int DATA_W = 8;
    localparam int LVL_W  = 7;
    localparam int STAT_W = 5;

    // bit 4 .. bit 0
    typedef struct packed {
        logic brk;
        logic per;
        logic fer;
        logic rxf;
        logic txe;
    } stat_t;

    function automatic logic [LVL_W-1:0] tx_trig(input logic [1:0] sel);
        case (sel)
            2'd0:    return LVL_W'(8);
            2'd1:    return LVL_W'(4);
            2'd2:    return LVL_W'(2);
            default: return LVL_W'(1);
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] rx_trig(input logic [1:0] sel);
        case (sel)
            2'd0:    return LVL_W'(1);
            2'd1:    return LVL_W'(4);
            2'd2:    return LVL_W'(8);
            default: return LVL_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          pop_ok, push_ok;

    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && ((count != CW'(DEPTH)) || pop_ok);
    assign dout    = mem[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) begin
                mem[wptr] <= din;
                wptr      <= bump(wptr);
            end
            if (pop_ok) rptr <= bump(rptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && count == CW'(DEPTH)) |=> count == CW'(DEPTH));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && count == '0) |=> count == '0);

    // R9
    pushpop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && count != '0 && count != CW'(DEPTH)) |=> count == $past(count));

endmodule

// File: rtl/sport_flag_bit.sv
module sport_flag_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic q
);
    logic armed;
    logic clr;

    assign clr = wr && !wbit && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= RST_VAL;
            armed <= 1'b0;
        end else begin
            if (set)      q <= 1'b1;
            else if (clr) q <= 1'b0;
            if (wr)       armed <= 1'b0;
            else if (rd)  armed <= q;
        end
    end

    // R8
    clear_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !armed && !set) |=> q == $past(q));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> q);

endmodule

// File: rtl/sport_rx_gate.sv
module sport_rx_gate
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              ferr,
    input  logic              idle,
    output logic              push,
    output logic              brk_evt
);
    logic in_brk;

    assign brk_evt = done && ferr && (data == '0);
    assign push    = done && !in_brk && !brk_evt;

    always_ff @(posedge clk) begin
        if (rst)          in_brk <= 1'b0;
        else if (brk_evt) in_brk <= 1'b1;
        else if (idle)    in_brk <= 1'b0;
    end

    // R11
    break_block_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_evt || (in_brk && !idle)) |=> !push);

endmodule

// File: rtl/sport_fifo_flags.sv
module sport_fifo_flags
    import sport_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        tx_trig_sel,
    input  logic [1:0]        rx_trig_sel,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              txe_take,
    output logic [DATA_W-1:0] txe_data,
    output logic              txe_valid,
    input  logic              rxe_done,
    input  logic [DATA_W-1:0] rxe_data,
    input  logic              rxe_ferr,
    input  logic              rxe_perr,
    input  logic              rxe_idle,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic [15:0]       level_q
);
    // DEPTH must lie in 14..127 so every trigger and the 7-bit count fit
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic             rx_push, brk_evt;
    stat_t            set_s;
    logic [STAT_W-1:0] set_v;

    sport_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk(clk), .rst(rst), .push(host_wr), .din(host_wdata),
        .pop(txe_take), .dout(txe_data), .count(tx_cnt));

    sport_rx_gate u_gate (
        .clk(clk), .rst(rst), .done(rxe_done), .data(rxe_data),
        .ferr(rxe_ferr), .idle(rxe_idle), .push(rx_push), .brk_evt(brk_evt));

    sport_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rxe_data),
        .pop(host_rd), .dout(host_rdata), .count(rx_cnt));

    assign tx_lvl    = LVL_W'(tx_cnt);
    assign rx_lvl    = LVL_W'(rx_cnt);
    assign txe_valid = (tx_cnt != '0);
    assign level_q   = {1'b0, tx_lvl, 1'b0, rx_lvl};

    always_comb begin
        set_s.txe = (tx_lvl <= tx_trig(tx_trig_sel));
        set_s.rxf = (rx_lvl >= rx_trig(rx_trig_sel));
        set_s.fer = rxe_done && rxe_ferr;
        set_s.per = rxe_done && rxe_perr;
        set_s.brk = brk_evt;
    end
    assign set_v = set_s;

    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        sport_flag_bit #(.RST_VAL(i == 0)) u_flag (
            .clk(clk), .rst(rst), .set(set_v[i]), .rd(stat_rd),
            .wr(stat_wr), .wbit(stat_wdata[i]), .q(stat_q[i]));
    end

    // R5
    tx_level_chk: assert property (@(posedge clk) disable iff (rst)
        (level_q[14:8] <= tx_trig(tx_trig_sel)) |=> stat_q[0]);

    // R6
    rx_level_chk: assert property (@(posedge clk) disable iff (rst)
        (level_q[6:0] >= rx_trig(rx_trig_sel)) |=> stat_q[1]);

endmodule

// File: tb/sim_sport_fifo_flags.sv
module sim_sport_fifo_flags;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tx_trig_sel = '0, rx_trig_sel = '0;
    logic       host_wr = 0, host_rd = 0, txe_take = 0;
    logic [7:0] host_wdata = '0, rxe_data = '0;
    logic [7:0] host_rdata, txe_data;
    logic       txe_valid;
    logic       rxe_done = 0, rxe_ferr = 0, rxe_perr = 0, rxe_idle = 0;
    logic       stat_rd = 0, stat_wr = 0;
    logic [4:0] stat_wdata = '1;
    logic [4:0] stat_q;
    logic [15:0] level_q;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sport_fifo_flags u0 (.*);

    function automatic int txt(input int s);
        return 8 >> s;
    endfunction

    function automatic int rxt(input int s);
        return (s == 0) ? 1 : (s == 3) ? 14 : 4 * s;
    endfunction

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tx_push(input logic [7:0] d);
        host_wr = 1; host_wdata = d; tick(); host_wr = 0;
    endtask

    task automatic tx_pop();
        txe_take = 1; tick(); txe_take = 0;
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic fe, input logic pe);
        rxe_done = 1; rxe_data = d; rxe_ferr = fe; rxe_perr = pe;
        tick();
        rxe_done = 0; rxe_ferr = 0; rxe_perr = 0;
    endtask

    task automatic rx_pop();
        host_rd = 1; tick(); host_rd = 0;
    endtask

    task automatic clear_flag(input int b);
        stat_rd = 1; tick(); stat_rd = 0;
        stat_wr = 1; stat_wdata = ~(5'b1 << b); tick();
        stat_wr = 0; stat_wdata = '1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 stat", stat_q, 1);
        chk("R1 level", level_q, 0);
        chk("R1 valid", txe_valid, 0);

        // transmit sweep: R5 R7 R4 R2
        for (int s = 0; s < 4; s++) begin
            tx_trig_sel = 2'(s);
            for (int l = 0; l <= 16; l++) begin
                if (l > 0) tx_push(8'(l + 16 * s));
                tick(2);
                clear_flag(0);
                tick();
                chk("R5/R7 tx flag", stat_q[0], int'(l <= txt(s)));
                chk("R4 tx count", level_q[14:8], l);
            end
            tx_push(8'hEE);
            tick();
            chk("R2 full write ignored", level_q[14:8], 16);
            for (int i = 1; i <= 16; i++) begin
                chk("R2 order", txe_data, (i + 16 * s) & 255);
                tx_pop();
            end
            chk("R2 drained", txe_valid, 0);
        end

        // receive sweep: R6 R7 R4 R3
        for (int s = 0; s < 4; s++) begin
            rx_trig_sel = 2'(s);
            for (int l = 0; l <= 16; l++) begin
                if (l > 0) rx_frame(8'(l + 20 * s), 0, 0);
                tick(2);
                clear_flag(1);
                tick();
                chk("R6/R7 rx flag", stat_q[1], int'(l >= rxt(s)));
                chk("R4 rx count", level_q[6:0], l);
                chk("R4 spare bits", {level_q[15], level_q[7]}, 0);
            end
            for (int i = 1; i <= 16; i++) begin
                chk("R3 order", host_rdata, (i + 20 * s) & 255);
                rx_pop();
            end
            rx_pop();
            tick();
            chk("R3 empty read ignored", level_q[6:0], 0);
        end

        // R9 simultaneous push and pop
        tx_push(8'h11); tx_push(8'h22); tx_push(8'h33);
        host_wr = 1; host_wdata = 8'h44; txe_take = 1; tick();
        host_wr = 0; txe_take = 0;
        chk("R9 tx count", level_q[14:8], 3);
        chk("R9 tx head", txe_data, 8'h22);
        repeat (3) tx_pop();
        rx_frame(8'h55, 0, 0); rx_frame(8'h66, 0, 0);
        rxe_done = 1; rxe_data = 8'h77; host_rd = 1; tick();
        rxe_done = 0; host_rd = 0;
        chk("R9 rx count", level_q[6:0], 2);
        chk("R9 rx head", host_rdata, 8'h66);
        rx_pop(); rx_pop();

        // R8 clear without prior read
        tx_trig_sel = 2'd0;
        tick(2);
        for (int i = 0; i < 10; i++) tx_push(8'(i));
        tick(2);
        chk("R8 flag sticky", stat_q[0], 1);
        stat_wr = 1; stat_wdata = 5'b11110; tick(); stat_wr = 0; stat_wdata = '1;
        tick();
        chk("R8 unarmed clear ignored", stat_q[0], 1);
        clear_flag(0);
        tick();
        chk("R8 armed clear", stat_q[0], 0);
        repeat (10) tx_pop();

        // R10 error flags
        rx_frame(8'h5A, 1, 0);
        chk("R10 fer", stat_q[2], 1);
        chk("R10 per clear", stat_q[3], 0);
        rx_frame(8'h33, 0, 1);
        chk("R10 per", stat_q[3], 1);
        chk("R10 stored", level_q[6:0], 2);
        clear_flag(2); clear_flag(3);
        tick();
        chk("R10 cleared", stat_q[3:2], 0);
        rx_pop(); rx_pop();

        // R11 break
        rx_frame(8'h00, 1, 1);
        chk("R11 break flags", stat_q[4:2], 7);
        chk("R11 break frame dropped", level_q[6:0], 0);
        rx_frame(8'h44, 0, 0);
        chk("R11 frame dropped in break", level_q[6:0], 0);

        // R12 break end
        rxe_idle = 1; tick(); rxe_idle = 0;
        rx_frame(8'h66, 0, 0);
        chk("R12 count", level_q[6:0], 1);
        chk("R12 data", host_rdata, 8'h66);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule